// File: doc/BRIEF.md
# GPS C/A Tracking Channel

This block is one despreading channel of a multi-channel satellite-navigation baseband. Every clock cycle brings one 1.5-bit intermediate-frequency sample, carried on a sign line and a magnitude line. The channel wipes off the residual carrier with a numerically controlled oscillator. It then multiplies the result by a locally generated 1023-chip Gold code at three replica positions spaced half a chip apart. The in-phase and quadrature products are summed for each replica over one full code period.

Firmware programs the channel with a pair of code-generator tap positions, which select the satellite, and with two 32-bit phase increments, one for the carrier and one for the code. At the default 23.104 MHz sample rate, a 4.348 MHz carrier needs an increment of about 2^32·0.1882. A code rate of 1.023 Mchip/s needs an increment of about 2^32·0.08856, because each overflow of the code accumulator is half a chip. A one-cycle load strobe restarts the code at its first chip. Each time the code wraps, the six sums are latched onto the outputs and a one-cycle strobe is raised. Several channels can be placed side by side, each with its own settings.

Top module: `gps_track_channel`

## Requirements
- R1: A sample is worth +1 or +3 when `sampleSign` is 0, and -1 or -3 when it is 1. `sampleMag` = 1 selects the magnitude 3.
- R2: The carrier phase is a 32-bit accumulator that adds `carrierStep` every cycle. Its top three bits k select the in-phase mix value from {+2,+1,-1,-2,-2,-1,+1,+2} and the quadrature mix value from {-1,-2,-2,-1,+1,+2,+2,+1}, both for k = 0..7.
- R3: The code phase is a 32-bit accumulator that adds `codeStep` every cycle. A carry out of that addition is a half-chip tick, and every second tick advances the code by one chip. With `codeStep` = 0x8000_0000, one chip therefore lasts four cycles.
- R4: The code is the XOR of stage 10 of generator A (feedback from stages 3 and 10) with stages `prnTapA` and `prnTapB` of generator B (feedback from stages 2, 3, 6, 8, 9 and 10). Both generators shift toward stage 10. A chip of logic 1 counts as -1.
- R5: The early, prompt and late replicas are the code chips captured at the most recent, second most recent and third most recent half-chip tick.
- R6: The code wraps when a chip advance brings generator A back to all ones. On that cycle the six outputs take the sums of all products since the previous wrap, not counting the product of the wrap cycle itself. That product opens the next sum.
- R7: `dumpValid` is high for exactly the one cycle after a wrap. The six outputs do not change in any other cycle.
- R8: On a cycle with `phaseLoad` high, both generators go to all ones, both phase accumulators and the replica line go to zero, the sums are cleared, and no wrap occurs. The first wrap after a load then falls 4092 cycles later at `codeStep` = 0x8000_0000.
- R9: A new value on `codeStep` or `carrierStep` is used for the very next sample. A `codeStep` of zero freezes the code.
- R10: While `rstN` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleSign | input | 1 | Sample polarity, 1 = negative |
| sampleMag | input | 1 | Sample magnitude, 1 = large |
| prnTapA | input | 4 | First generator B tap (1..10) |
| prnTapB | input | 4 | Second generator B tap (1..10) |
| carrierStep | input | 32 | Carrier phase increment per sample |
| codeStep | input | 32 | Code phase increment per sample (half chip per carry) |
| phaseLoad | input | 1 | Restart the code at chip zero |
| earlyI | output | ACC_W | Early in-phase sum |
| earlyQ | output | ACC_W | Early quadrature sum |
| promptI | output | ACC_W | Prompt in-phase sum |
| promptQ | output | ACC_W | Prompt quadrature sum |
| lateI | output | ACC_W | Late in-phase sum |
| lateQ | output | ACC_W | Late quadrature sum |
| dumpValid | output | 1 | One-cycle strobe after a code wrap |

## Verification
The bench feeds the channel a replica of a satellite code that lines up exactly with the prompt position. A tap line that is off by one half-chip tick would shift the full-height peak onto the early or late output, and that shows up in all three sums. The same input with a different tap pair must give the small cross-correlation value. A generator with a wrong feedback or tap would lose the peak. Constant-sample runs, with and without a rotating carrier, check the mix tables and the sample mapping. A window that is off by one cycle would change every sum by one product and would move the strobe from cycle 4092 and 8184 after the load. A freeze test holds the code increment at zero for 100 cycles and expects every wrap to move by exactly 100 cycles.

// File: rtl/gpsch_pkg.sv
package gpsch_pkg;
  localparam int SR_LEN   = 10;
  localparam int TAP_W    = 4;
  localparam int NUM_TAPS = 3;
  localparam int LUT_BITS = 3;

  typedef struct packed {
    logic halfTick;
    logic epoch;
    logic restart;
  } chStrobe_t;
endpackage

// File: rtl/gpsch_ctrl.sv
module gpsch_ctrl
  import gpsch_pkg::*;
#(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TAP_W-1:0]   prnTapA,
  input  logic [TAP_W-1:0]   prnTapB,
  input  logic [PHASE_W-1:0] codeStep,
  input  logic               phaseLoad,
  output chStrobe_t          stb,
  output logic               codeChip
);
  logic [PHASE_W-1:0] codeAcc;
  logic [PHASE_W:0]   codeSum;
  logic               halfSel;
  logic [SR_LEN:1]    genA, genB, genANext, genBNext;
  logic               tickNow, advNow;

  function automatic logic pickStage(input logic [SR_LEN:1] sr, input logic [TAP_W-1:0] sel);
    logic r;
    r = 1'b0;
    for (int i = 1; i <= SR_LEN; i++) begin
      if (sel == TAP_W'(i)) r = sr[i];
    end
    return r;
  endfunction

  assign codeSum  = {1'b0, codeAcc} + {1'b0, codeStep};
  assign tickNow  = codeSum[PHASE_W] && !phaseLoad;
  assign advNow   = tickNow && halfSel;
  assign genANext = {genA[SR_LEN-1:1], genA[3] ^ genA[10]};
  assign genBNext = {genB[SR_LEN-1:1],
                     genB[2] ^ genB[3] ^ genB[6] ^ genB[8] ^ genB[9] ^ genB[10]};
  assign codeChip = genA[SR_LEN] ^ pickStage(genB, prnTapA) ^ pickStage(genB, prnTapB);

  always_comb begin
    stb.halfTick = tickNow;
    stb.epoch    = advNow && (&genANext);
    stb.restart  = phaseLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeAcc <= '0;
      halfSel <= 1'b0;
      genA    <= '1;
      genB    <= '1;
    end else if (phaseLoad) begin
      codeAcc <= '0;
      halfSel <= 1'b0;
      genA    <= '1;
      genB    <= '1;
    end else begin
      codeAcc <= codeSum[PHASE_W-1:0];
      if (tickNow) halfSel <= !halfSel;
      if (advNow) begin
        genA <= genANext;
        genB <= genBNext;
      end
    end
  end
endmodule

// File: rtl/gpsch_datapath.sv
module gpsch_datapath
  import gpsch_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int ACC_W   = 20
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  chStrobe_t                         stb,
  input  logic                              codeChip,
  input  logic                              sampleSign,
  input  logic                              sampleMag,
  input  logic [PHASE_W-1:0]                carrierStep,
  output logic [NUM_TAPS-1:0][ACC_W-1:0]    dumpI,
  output logic [NUM_TAPS-1:0][ACC_W-1:0]    dumpQ,
  output logic                              dumpValid
);
  localparam int PROD_W = 4;

  logic [PHASE_W-1:0]  carAcc;
  logic [LUT_BITS-1:0] carIdx;
  logic [NUM_TAPS-1:0] tapLine;
  logic signed [2:0]   smpVal, mixI, mixQ;
  logic signed [PROD_W-1:0] baseI, baseQ;

  function automatic logic signed [2:0] cosLut(input logic [LUT_BITS-1:0] k);
    case (k)
      3'd0, 3'd7: return 3'sd2;
      3'd1, 3'd6: return 3'sd1;
      3'd2, 3'd5: return -3'sd1;
      default:    return -3'sd2;
    endcase
  endfunction

  function automatic logic signed [2:0] negSinLut(input logic [LUT_BITS-1:0] k);
    case (k)
      3'd0, 3'd3: return -3'sd1;
      3'd1, 3'd2: return -3'sd2;
      3'd4, 3'd7: return 3'sd1;
      default:    return 3'sd2;
    endcase
  endfunction

  assign carIdx = carAcc[PHASE_W-1 -: LUT_BITS];
  assign smpVal = sampleSign ? (sampleMag ? -3'sd3 : -3'sd1) : (sampleMag ? 3'sd3 : 3'sd1);
  assign mixI   = cosLut(carIdx);
  assign mixQ   = negSinLut(carIdx);
  assign baseI  = PROD_W'(smpVal) * PROD_W'(mixI);
  assign baseQ  = PROD_W'(smpVal) * PROD_W'(mixQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carAcc    <= '0;
      tapLine   <= '0;
      dumpValid <= 1'b0;
    end else begin
      dumpValid <= stb.epoch;
      if (stb.restart) begin
        carAcc  <= '0;
        tapLine <= '0;
      end else begin
        carAcc <= carAcc + carrierStep;
        if (stb.halfTick) tapLine <= {tapLine[NUM_TAPS-2:0], codeChip};
      end
    end
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    logic [ACC_W-1:0] extI, extQ, prodI, prodQ, accI, accQ;

    assign extI  = {{(ACC_W-PROD_W){baseI[PROD_W-1]}}, baseI};
    assign extQ  = {{(ACC_W-PROD_W){baseQ[PROD_W-1]}}, baseQ};
    assign prodI = tapLine[t] ? (~extI + 1'b1) : extI;
    assign prodQ = tapLine[t] ? (~extQ + 1'b1) : extQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        accI     <= '0;
        accQ     <= '0;
        dumpI[t] <= '0;
        dumpQ[t] <= '0;
      end else if (stb.restart) begin
        accI <= '0;
        accQ <= '0;
      end else if (stb.epoch) begin
        dumpI[t] <= accI;
        dumpQ[t] <= accQ;
        accI     <= prodI;
        accQ     <= prodQ;
      end else begin
        accI <= accI + prodI;
        accQ <= accQ + prodQ;
      end
    end
  end
endmodule

// File: rtl/gps_track_channel.sv
module gps_track_channel
  import gpsch_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int ACC_W   = 20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleSign,
  input  logic                     sampleMag,
  input  logic [3:0]               prnTapA,
  input  logic [3:0]               prnTapB,
  input  logic [PHASE_W-1:0]       carrierStep,
  input  logic [PHASE_W-1:0]       codeStep,
  input  logic                     phaseLoad,
  output logic signed [ACC_W-1:0]  earlyI,
  output logic signed [ACC_W-1:0]  earlyQ,
  output logic signed [ACC_W-1:0]  promptI,
  output logic signed [ACC_W-1:0]  promptQ,
  output logic signed [ACC_W-1:0]  lateI,
  output logic signed [ACC_W-1:0]  lateQ,
  output logic                     dumpValid
);
  chStrobe_t stb;
  logic      codeChip;
  logic [NUM_TAPS-1:0][ACC_W-1:0] dumpI, dumpQ;

  gpsch_ctrl #(.PHASE_W(PHASE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .prnTapA(prnTapA), .prnTapB(prnTapB),
    .codeStep(codeStep), .phaseLoad(phaseLoad), .stb(stb), .codeChip(codeChip)
  );

  gpsch_datapath #(.PHASE_W(PHASE_W), .ACC_W(ACC_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .codeChip(codeChip),
    .sampleSign(sampleSign), .sampleMag(sampleMag), .carrierStep(carrierStep),
    .dumpI(dumpI), .dumpQ(dumpQ), .dumpValid(dumpValid)
  );

  assign earlyI  = dumpI[0];
  assign earlyQ  = dumpQ[0];
  assign promptI = dumpI[1];
  assign promptQ = dumpQ[1];
  assign lateI   = dumpI[2];
  assign lateQ   = dumpQ[2];
endmodule

// File: rtl/gps_track_channel_chk.sv
module gps_track_channel_chk #(
  parameter int ACC_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             phaseLoad,
  input logic [ACC_W-1:0] earlyI,
  input logic [ACC_W-1:0] earlyQ,
  input logic [ACC_W-1:0] promptI,
  input logic [ACC_W-1:0] promptQ,
  input logic [ACC_W-1:0] lateI,
  input logic [ACC_W-1:0] lateQ,
  input logic             dumpValid
);
  localparam int GAP_W   = 12;
  localparam int MIN_GAP = 2000;

  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gapCnt <= '0;
    else if (phaseLoad || dumpValid) gapCnt <= '0;
    else if (gapCnt != '1) gapCnt <= gapCnt + 1'b1;
  end

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!dumpValid && promptI == '0 && promptQ == '0 && earlyI == '0 && lateQ == '0));

  // R7
  dump_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dumpValid |=> !dumpValid);

  // R7
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dumpValid |-> ($stable(earlyI) && $stable(earlyQ) && $stable(promptI) &&
                    $stable(promptQ) && $stable(lateI) && $stable(lateQ)));

  // R8
  load_no_dump_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseLoad |=> !dumpValid);

  // R6
  epoch_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    dumpValid |-> (gapCnt >= GAP_W'(MIN_GAP)));
endmodule

bind gps_track_channel gps_track_channel_chk #(.ACC_W(ACC_W)) uChk (
  .clk(clk), .rstN(rstN), .phaseLoad(phaseLoad),
  .earlyI(earlyI), .earlyQ(earlyQ), .promptI(promptI), .promptQ(promptQ),
  .lateI(lateI), .lateQ(lateQ), .dumpValid(dumpValid)
);

// File: tb/gps_track_channel_test.sv
module gps_track_channel_test;
  localparam int ACC_W  = 20;
  localparam int PERIOD = 4092;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleSign = 1'b0, sampleMag = 1'b0;
  logic [3:0] prnTapA = 4'd2, prnTapB = 4'd6;
  logic [31:0] carrierStep = '0, codeStep = '0;
  logic phaseLoad = 1'b0;
  logic signed [ACC_W-1:0] earlyI, earlyQ, promptI, promptQ, lateI, lateQ;
  logic dumpValid;

  int checks = 0;
  int fails = 0;
  bit codeIn [1023];
  bit codeLoc [1023];

  always #5 clk = ~clk;

  gps_track_channel #(.ACC_W(ACC_W)) uut (
    .clk(clk), .rstN(rstN), .sampleSign(sampleSign), .sampleMag(sampleMag),
    .prnTapA(prnTapA), .prnTapB(prnTapB), .carrierStep(carrierStep),
    .codeStep(codeStep), .phaseLoad(phaseLoad),
    .earlyI(earlyI), .earlyQ(earlyQ), .promptI(promptI), .promptQ(promptQ),
    .lateI(lateI), .lateQ(lateQ), .dumpValid(dumpValid)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // R4 model: generator A taps 3,10; generator B taps 2,3,6,8,9,10
  task automatic buildCode(input int ta, input int tb, input bit toLocal);
    bit [10:1] a, b;
    bit chip, fa, fb;
    a = '1;
    b = '1;
    for (int j = 0; j < 1023; j++) begin
      chip = a[10] ^ b[ta] ^ b[tb];
      if (toLocal) codeLoc[j] = chip; else codeIn[j] = chip;
      fa = a[3] ^ a[10];
      fb = b[2] ^ b[3] ^ b[6] ^ b[8] ^ b[9] ^ b[10];
      a = {a[9:1], fa};
      b = {b[9:1], fb};
    end
  endtask

  function automatic int lutI(input bit [2:0] k);
    int t [8] = '{2, 1, -1, -2, -2, -1, 1, 2};
    return t[k];
  endfunction

  function automatic int lutQ(input bit [2:0] k);
    int t [8] = '{-1, -2, -2, -1, 1, 2, 2, 1};
    return t[k];
  endfunction

  function automatic int sampleAt(input int n, input bit inCode, input bit cs, input bit cm);
    bit s;
    bit m;
    s = inCode ? ((n >= 4) ? codeIn[((n - 4) / 4) % 1023] : 1'b0) : cs;
    m = inCode ? 1'b1 : cm;
    return (s ? -1 : 1) * (m ? 3 : 1);
  endfunction

  // expected sum over the second window (cycles 4091..8182 after load)
  function automatic int expSum(input int tap, input bit isQ, input bit inCode,
                                input bit cs, input bit cm, input bit [31:0] cstep);
    int s;
    s = 0;
    for (int n = PERIOD - 1; n < 2 * PERIOD - 1; n++) begin
      bit [31:0] ph;
      int mix;
      int cp;
      ph  = cstep * n;
      mix = isQ ? lutQ(ph[31:29]) : lutI(ph[31:29]);
      cp  = codeLoc[((n - 2 * (tap + 1)) / 4) % 1023] ? -1 : 1;
      s  += sampleAt(n, inCode, cs, cm) * mix * cp;
    end
    return s;
  endfunction

  task automatic runCase(input string nm, input int ta, input int tb, input bit inCode,
                         input bit cs, input bit cm, input int ita, input int itb,
                         input bit [31:0] cstep, input int freeze);
    int firstSeen, secondSeen, lastN, smp;
    int got [6];
    firstSeen  = -1;
    secondSeen = -1;
    lastN = 2 * PERIOD + freeze + 3;
    buildCode(ta, tb, 1'b1);
    buildCode(ita, itb, 1'b0);
    @(negedge clk);
    prnTapA     = 4'(ta);
    prnTapB     = 4'(tb);
    carrierStep = cstep;
    codeStep    = (freeze > 0) ? 32'h0 : 32'h8000_0000;
    phaseLoad   = 1'b1;
    for (int n = 0; n < lastN; n++) begin
      @(negedge clk);
      phaseLoad = 1'b0;
      if (n == freeze) codeStep = 32'h8000_0000;
      if (n > 0 && n == secondSeen + 1)
        checkEq({nm, " R7 strobe width"}, int'(dumpValid), 0);
      if (dumpValid) begin
        if (firstSeen < 0) firstSeen = n;
        else if (secondSeen < 0) begin
          secondSeen = n;
          got = '{int'(earlyI), int'(earlyQ), int'(promptI), int'(promptQ), int'(lateI), int'(lateQ)};
        end else checkEq({nm, " R6 extra wrap at cycle"}, n, -1);
      end
      if (n == lastN - 1)
        checkEq({nm, " R7 prompt I held"}, int'(promptI), got[2]);
      smp = sampleAt(n, inCode, cs, cm);
      sampleSign = (smp < 0);
      sampleMag  = (smp == 3 || smp == -3);
    end
    checkEq({nm, " R8 first wrap cycle"}, firstSeen, PERIOD + freeze);
    checkEq({nm, " R3 R6 second wrap cycle"}, secondSeen, 2 * PERIOD + freeze);
    if (freeze == 0) begin
      checkEq({nm, " R5 early I"},  got[0], expSum(0, 1'b0, inCode, cs, cm, cstep));
      checkEq({nm, " R5 early Q"},  got[1], expSum(0, 1'b1, inCode, cs, cm, cstep));
      checkEq({nm, " R4 prompt I"}, got[2], expSum(1, 1'b0, inCode, cs, cm, cstep));
      checkEq({nm, " R2 prompt Q"}, got[3], expSum(1, 1'b1, inCode, cs, cm, cstep));
      checkEq({nm, " R5 late I"},   got[4], expSum(2, 1'b0, inCode, cs, cm, cstep));
      checkEq({nm, " R5 late Q"},   got[5], expSum(2, 1'b1, inCode, cs, cm, cstep));
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    checkEq("R10 dumpValid", int'(dumpValid), 0);
    checkEq("R10 earlyI", int'(earlyI), 0);
    checkEq("R10 earlyQ", int'(earlyQ), 0);
    checkEq("R10 promptI", int'(promptI), 0);
    checkEq("R10 promptQ", int'(promptQ), 0);
    checkEq("R10 lateI", int'(lateI), 0);
    checkEq("R10 lateQ", int'(lateQ), 0);
  endtask

  // R1 R2: large positive samples, carrier held at phase zero: sums are -24 and +12
  task automatic testConstLarge();
    runCase("constLarge", 2, 6, 1'b0, 1'b0, 1'b1, 2, 6, 32'h0, 0);
    checkEq("R1 known prompt I value", expSum(1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0), -24);
  endtask

  // R1 R2: small negative samples, rotating carrier, other code
  task automatic testConstSmallRot();
    runCase("constSmallRot", 1, 9, 1'b0, 1'b1, 1'b0, 1, 9, 32'h2000_0000, 0);
  endtask

  // R4 R5: matched code aligned to prompt, peak 6 x 4092
  task automatic testMatched();
    runCase("matched", 2, 6, 1'b1, 1'b0, 1'b0, 2, 6, 32'h0, 0);
    checkEq("R4 matched peak", expSum(1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0), 24552);
  endtask

  // R4: mismatched code selection
  task automatic testMismatch();
    runCase("mismatch", 3, 7, 1'b1, 1'b0, 1'b0, 2, 6, 32'h0, 0);
  endtask

  // R2 R4: matched code under an arbitrary carrier increment
  task automatic testCarrier();
    runCase("carrier", 5, 9, 1'b1, 1'b0, 1'b0, 5, 9, 32'h1234_5678, 0);
  endtask

  // R9: code frozen 100 cycles, then running
  task automatic testFreeze();
    runCase("freeze R9", 2, 6, 1'b0, 1'b0, 1'b1, 2, 6, 32'h0, 100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog: actual 200000 cycles expected completion earlier");
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testConstLarge();
    testConstSmallRot();
    testMatched();
    testMismatch();
    testCarrier();
    testFreeze();
    finishRun();
  end
endmodule